// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Interface

This block is the digital front end of a four-channel, 12-bit voltage-output converter with readback. A parallel host port selects one of four channels with a 2-bit select, and a read/write strobe qualified by an active-low chip select either writes the data bus into that channel's input register or returns that input register on the bus. Each channel has a second, output register whose value is the code the converter drives. The output registers change only in three ways. A global load strobe copies all four input registers across at once. A write made while the load strobe is low also goes straight into the addressed output register. Reset forces every register to a fixed code.

All host controls and the data bus pass through a synchronizer chain on the system clock, and every action is taken on clock edges. This keeps the register bank in one clock domain. The bidirectional data pins are modelled as a separate data input, data output and output enable, with exactly one side driving at any time. Codes are straight binary: the converter output equals the low reference plus the reference span times N/4096. A parameter picks the reset code, either midscale or zero scale.

Top module: `qdac_regbank`

## Requirements
- R1: While `rst_n` is low, all input and output registers take the reset code at the next clock edge: 0x800 when `RST_MID`=1, 0x000 when `RST_MID`=0. `dout_oe` is low and `dout` is 0 after reset.
- R2: `sel` picks the channel: 0 is A, 1 is B, 2 is C, 3 is D. `code_out` carries channel A in bits 11:0, B in 23:12, C in 35:24 and D in 47:36.
- R3: With `cs_n` low and `rw` low, `din` is written into the selected channel's input register. While `ld_n` stays high, no output register changes.
- R4: With `cs_n` low and `rw` high, `dout_oe` is high and `dout` equals the selected channel's input register. At all other times `dout_oe` is low and `dout` is 0.
- R5: While `cs_n` is high, `rw`, `sel` and `din` write and read nothing.
- R6: A global transfer happens when `ld_n` rises after being low, with `cs_n` high, for at least `LD_MIN_CYC` consecutive clock cycles. All four output registers then load their input registers at once. A shorter low pulse transfers nothing.
- R7: A write made while `ld_n` is low loads `din` into both the input register and the output register of the addressed channel only. The other output registers are unchanged.
- R8: When a write and a global transfer fall in the same cycle, the written channel's output register receives the newly written data, and every other channel receives its input register.
- R9: Reset acts regardless of `cs_n`, including in the middle of a write access.
- R10: An input change takes effect on the (`SYNC_STAGES`+1)-th rising clock edge after it is presented: the third edge by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the register bank, independent of chip select |
| sel | input | 2 | Channel select (0=A .. 3=D) |
| rw | input | 1 | Access direction: 1 read, 0 write |
| cs_n | input | 1 | Active-low chip select qualifying `sel` and `rw` |
| ld_n | input | 1 | Active-low load strobe for transfers to the output registers |
| din | input | 12 | Host write data, bit 11 MSB |
| dout | output | 12 | Readback data, 0 when not driving |
| dout_oe | output | 1 | High while the block drives the data bus |
| code_out | output | 48 | Four output-register codes, channel A in the low bits |

## Verification
Writes with the load strobe high are tried on each of the four channels with distinct data. Reading back all four checks the select decode, and the unchanged outputs show that the two register banks are separate. Load pulses one cycle shorter than, and exactly equal to, the minimum are compared to separate a missing width check from an off-by-one. A transparent write is then done with the load strobe low, and a write is made in the very cycle the strobe rises, to tell the single-channel path apart from the global copy and to settle their priority. A reset is issued in the middle of a selected write, on two instances with different reset codes, to show that reset does not depend on chip select and that each variant uses its own code.

// File: rtl/qdac_pkg.sv
// Package: shared types and helpers for the quad DAC register bank.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package qdac_pkg;

    // Kind of host access decoded from chip select and read/write
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_e;

    // Reset code for a data width: midscale (MSB only) or zero scale
    function automatic logic [31:0] reset_code(input int unsigned dw, input bit mid);
        logic [31:0] r;
        r = '0;
        if (mid) begin
            r[dw-1] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
// Module: qdac_sync
// Passes a bundle of host inputs through STAGES flip-flops on clk.
// Assumes STAGES >= 1; reset loads RST_VAL (the idle level of each bit).
module qdac_sync #(
    parameter int unsigned W       = 8,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the bundle one stage per clock; synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/qdac_ctrl.sv
// Module: qdac_ctrl
// Decodes synchronized host controls into per-channel write enables,
// a readback enable, a write-through flag and a global transfer pulse.
// The transfer fires on the cycle the load strobe is first seen high,
// provided it was low with chip select high for LD_MIN_CYC cycles.
module qdac_ctrl
    import qdac_pkg::*;
#(
    parameter int unsigned NCH        = 4,
    parameter int unsigned LD_MIN_CYC = 34,
    localparam int unsigned AW        = $clog2(NCH),
    localparam int unsigned CW        = $clog2(LD_MIN_CYC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_cs_n,
    input  logic           s_rw,
    input  logic           s_ld_n,
    input  logic [AW-1:0]  s_sel,
    output logic [NCH-1:0] wr_en,
    output logic           wr_thru,
    output logic           rd_en,
    output logic           xfer
);

    acc_e          acc;
    logic [CW-1:0] low_cnt;
    logic          ld_prev;

    // Classify the current access from chip select and direction
    always_comb begin
        if (s_cs_n) begin
            acc = ACC_IDLE;
        end else if (s_rw) begin
            acc = ACC_READ;
        end else begin
            acc = ACC_WRITE;
        end
    end

    // One write enable per channel from the select decode
    for (genvar g = 0; g < int'(NCH); g++) begin : g_dec
        assign wr_en[g] = (acc == ACC_WRITE) && (s_sel == AW'(g));
    end

    assign rd_en   = (acc == ACC_READ);
    assign wr_thru = !s_ld_n;

    // Count deselected load-low cycles (saturating) and remember the last strobe level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            ld_prev <= 1'b1;
        end else begin
            ld_prev <= s_ld_n;
            if (s_ld_n) begin
                low_cnt <= '0;
            end else if (s_cs_n && (low_cnt < CW'(LD_MIN_CYC))) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    // Transfer on the rising strobe once the low time met the minimum
    assign xfer = s_ld_n && !ld_prev && (low_cnt >= CW'(LD_MIN_CYC));

endmodule

// File: rtl/qdac_chan.sv
// Module: qdac_chan
// One channel: an input register written by the host and an output
// register feeding the converter. Writes with write-through or during a
// transfer win over the copy from the input register.
module qdac_chan #(
    parameter int unsigned   DW       = 12,
    parameter logic [DW-1:0] RST_CODE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          thru,
    input  logic          xfer,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] in_q,
    output logic [DW-1:0] out_q
);

    // Input register: host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= RST_CODE;
        end else if (we) begin
            in_q <= din;
        end
    end

    // Output register: write-through or transfer, new data has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= RST_CODE;
        end else if (we && (thru || xfer)) begin
            out_q <= din;
        end else if (xfer) begin
            out_q <= in_q;
        end
    end

endmodule

// File: rtl/qdac_regbank.sv
// Module: qdac_regbank (top)
// Host-facing register bank of a four-channel double-buffered DAC.
// Host controls and data are synchronized SYNC_STAGES deep, then decoded;
// readback is registered once more. RST_MID picks midscale or zero reset.
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter int unsigned DW          = 12,
    parameter int unsigned NCH         = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LD_MIN_CYC  = 34,
    parameter bit          RST_MID     = 1'b1,
    localparam int unsigned AW         = $clog2(NCH),
    localparam int unsigned SW         = 3 + AW + DW,
    localparam logic [DW-1:0] RST_CODE = DW'(reset_code(DW, RST_MID))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     sel,
    input  logic              rw,
    input  logic              cs_n,
    input  logic              ld_n,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_oe,
    output logic [NCH*DW-1:0] code_out
);

    localparam logic [SW-1:0] SYNC_IDLE = {3'b111, {(AW + DW){1'b0}}};

    logic [SW-1:0]     sync_q;
    logic              s_cs_n;
    logic              s_rw;
    logic              s_ld_n;
    logic [AW-1:0]     s_sel;
    logic [DW-1:0]     s_din;
    logic [NCH-1:0]    wr_en;
    logic              wr_thru;
    logic              rd_en;
    logic              xfer;
    logic [DW-1:0]     in_arr [NCH];
    logic [NCH*DW-1:0] in_flat;
    logic [NCH*DW-1:0] out_flat;
    logic [DW-1:0]     rd_q;
    logic              oe_q;

    qdac_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rw, ld_n, sel, din}),
        .q     (sync_q)
    );

    assign {s_cs_n, s_rw, s_ld_n, s_sel, s_din} = sync_q;

    qdac_ctrl #(
        .NCH        (NCH),
        .LD_MIN_CYC (LD_MIN_CYC)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_cs_n  (s_cs_n),
        .s_rw    (s_rw),
        .s_ld_n  (s_ld_n),
        .s_sel   (s_sel),
        .wr_en   (wr_en),
        .wr_thru (wr_thru),
        .rd_en   (rd_en),
        .xfer    (xfer)
    );

    for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
        logic [DW-1:0] in_q;
        logic [DW-1:0] out_q;

        qdac_chan #(
            .DW       (DW),
            .RST_CODE (RST_CODE)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en[g]),
            .thru  (wr_thru),
            .xfer  (xfer),
            .din   (s_din),
            .in_q  (in_q),
            .out_q (out_q)
        );

        assign in_arr[g]            = in_q;
        assign in_flat[g*DW +: DW]  = in_q;
        assign out_flat[g*DW +: DW] = out_q;
    end

    // Register the readback word and its bus enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            oe_q <= 1'b0;
        end else begin
            oe_q <= rd_en;
            rd_q <= rd_en ? in_arr[s_sel] : '0;
        end
    end

    assign dout     = rd_q;
    assign dout_oe  = oe_q;
    assign code_out = out_flat;

endmodule

// File: rtl/qdac_regbank_chk.sv
// Module: qdac_regbank_chk
// Property checker bound into qdac_regbank; observes ports and the
// decoded controls between the synchronizer, decoder and channels.
module qdac_regbank_chk #(
    parameter int unsigned DW  = 12,
    parameter int unsigned NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_cs_n,
    input logic              s_rw,
    input logic [NCH-1:0]    wr_en,
    input logic              wr_thru,
    input logic              xfer,
    input logic [NCH*DW-1:0] in_flat,
    input logic [NCH*DW-1:0] code_out,
    input logic [DW-1:0]     dout,
    input logic              dout_oe
);

    AST_WR_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !((|wr_en) && wr_thru)) |=> $stable(code_out)); // R3

    AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(!s_cs_n && s_rw)); // R4

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0)); // R4

    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |=> $stable(in_flat)); // R5

    AST_XFER_COPIES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !(|wr_en)) |=> (code_out == $past(in_flat))); // R6

endmodule

bind qdac_regbank qdac_regbank_chk #(
    .DW  (DW),
    .NCH (NCH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_cs_n   (s_cs_n),
    .s_rw     (s_rw),
    .wr_en    (wr_en),
    .wr_thru  (wr_thru),
    .xfer     (xfer),
    .in_flat  (in_flat),
    .code_out (code_out),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/sim_qdac_regbank.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, expected values from the requirements.
module sim_qdac_regbank;

    localparam int LAT  = 3;   // R10: SYNC_STAGES + 1 edges
    localparam int MINC = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = '0;
    logic        rw = 1'b1;
    logic        cs_n = 1'b1;
    logic        ld_n = 1'b1;
    logic [11:0] din = '0;
    logic [11:0] dout, dout1;
    logic        dout_oe, dout_oe1;
    logic [47:0] code_out, code_out1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [11:0] exp_in  [4];
    logic [11:0] exp_out [4];

    always #2.5 clk = ~clk;

    qdac_regbank #(.RST_MID(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rw(rw), .cs_n(cs_n), .ld_n(ld_n),
        .din(din), .dout(dout), .dout_oe(dout_oe), .code_out(code_out));

    qdac_regbank #(.RST_MID(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rw(rw), .cs_n(cs_n), .ld_n(ld_n),
        .din(din), .dout(dout1), .dout_oe(dout_oe1), .code_out(code_out1));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_vec();
        return {exp_out[3], exp_out[2], exp_out[1], exp_out[0]};
    endfunction

    task automatic do_write(input logic [1:0] ch, input logic [11:0] d, input logic ld);
        sel = ch; din = d; rw = 1'b0; cs_n = 1'b0; ld_n = ld;
        tick(1);
        cs_n = 1'b1; rw = 1'b1; ld_n = 1'b1;
        tick(LAT + 1);
        exp_in[ch] = d;
        if (!ld) exp_out[ch] = d;
    endtask

    task automatic do_read(input logic [1:0] ch, output logic [11:0] v, output logic oe);
        sel = ch; rw = 1'b1; cs_n = 1'b0;
        tick(LAT);
        v = dout; oe = dout_oe;
        cs_n = 1'b1;
        tick(LAT);
    endtask

    task automatic ld_pulse(input int len);
        ld_n = 1'b0;
        tick(len);
        ld_n = 1'b1;
        tick(LAT + 1);
        if (len >= MINC) begin
            for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
        end
    endtask

    // R1: reset values for both variants, bus idle
    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        for (int i = 0; i < 4; i++) begin
            exp_in[i] = 12'h800; exp_out[i] = 12'h800;
        end
        chk("R1 midscale outputs", code_out, exp_vec());
        chk("R1 zero-scale outputs", code_out1, 48'h0);
        chk("R1 oe low after reset", {47'h0, dout_oe}, 48'h0);
        chk("R1 dout zero after reset", {36'h0, dout}, 48'h0);
    endtask

    // R2 R3 R4 R10: write each channel with load high, read all back
    task automatic t_write_read();
        logic [11:0] v; logic oe;
        logic [11:0] pat [4];
        pat[0] = 12'h123; pat[1] = 12'hA5C; pat[2] = 12'hFFF; pat[3] = 12'h001;
        sel = 2'd2; din = 12'h777; rw = 1'b0; cs_n = 1'b0;
        tick(1);
        cs_n = 1'b1; rw = 1'b1;
        tick(LAT - 1);
        chk("R10 no oe during write", {47'h0, dout_oe}, 48'h0);
        tick(2);
        exp_in[2] = 12'h777;
        for (int i = 0; i < 4; i++) do_write(2'(i), pat[i], 1'b1);
        chk("R3 outputs hold while load high", code_out, exp_vec());
        for (int i = 0; i < 4; i++) begin
            do_read(2'(i), v, oe);
            chk($sformatf("R2 R4 readback channel %0d", i), {36'h0, v}, {36'h0, pat[i]});
            chk("R4 oe during read", {47'h0, oe}, 48'h1);
        end
        chk("R4 oe low after read", {47'h0, dout_oe}, 48'h0);
    endtask

    // R10: readback appears on the third edge, not before
    task automatic t_latency();
        sel = 2'd1; rw = 1'b1; cs_n = 1'b0;
        tick(LAT - 1);
        chk("R10 oe not yet high", {47'h0, dout_oe}, 48'h0);
        tick(1);
        chk("R10 readback on third edge", {36'h0, dout}, {36'h0, exp_in[1]});
        cs_n = 1'b1;
        tick(LAT);
    endtask

    // R5: write strobe with chip select high changes nothing
    task automatic t_deselected();
        logic [11:0] v; logic oe;
        sel = 2'd0; din = 12'hBAD; rw = 1'b0; cs_n = 1'b1;
        tick(LAT + 2);
        chk("R5 no oe while deselected", {47'h0, dout_oe}, 48'h0);
        rw = 1'b1;
        tick(1);
        do_read(2'd0, v, oe);
        chk("R5 input reg unchanged", {36'h0, v}, {36'h0, exp_in[0]});
        chk("R5 outputs unchanged", code_out, exp_vec());
    endtask

    // R6: short pulse ignored, minimum pulse transfers all
    task automatic t_transfer();
        ld_pulse(MINC - 1);
        chk("R6 short load pulse ignored", code_out, exp_vec());
        ld_pulse(MINC);
        chk("R6 minimum load pulse transfers", code_out, exp_vec());
    endtask

    // R7: write with load low goes through to one output only
    task automatic t_thru();
        do_write(2'd3, 12'h3C3, 1'b1);
        do_write(2'd1, 12'h5A5, 1'b0);
        chk("R7 write-through only addressed channel", code_out, exp_vec());
    endtask

    // R8: write in the same cycle as the transfer
    task automatic t_coincide();
        do_write(2'd0, 12'h0F0, 1'b1);
        ld_n = 1'b0;
        tick(MINC);
        ld_n = 1'b1; sel = 2'd2; din = 12'hE1E; rw = 1'b0; cs_n = 1'b0;
        tick(1);
        cs_n = 1'b1; rw = 1'b1;
        tick(LAT + 1);
        for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
        exp_in[2] = 12'hE1E; exp_out[2] = 12'hE1E;
        chk("R8 new data wins on coincident transfer", code_out, exp_vec());
    endtask

    // R9 R1: reset in the middle of a selected write
    task automatic t_reset_busy();
        logic [11:0] v; logic oe;
        sel = 2'd1; din = 12'h9AB; rw = 1'b0; cs_n = 1'b0;
        tick(LAT + 1);
        rst_n = 1'b0;
        tick(1);
        for (int i = 0; i < 4; i++) exp_out[i] = 12'h800;
        chk("R9 reset during write, midscale", code_out, exp_vec());
        chk("R9 reset during write, zero scale", code_out1, 48'h0);
        cs_n = 1'b1; rw = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        do_read(2'd1, v, oe);
        chk("R9 input reg reset despite select", {36'h0, v}, 48'h800);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_latency();
        t_deselected();
        t_transfer();
        t_thru();
        t_coincide();
        t_reset_busy();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule